// File: doc/BRIEF.md
# Interrupt Entry and Halt Sequencer

This block is the boundary controller of an 8-bit processor core. Whenever the core sits between instructions and raises `boundary`, the sequencer chooses one of three things: hold the core (stop or DMA in progress), enter an interrupt, or grant the next opcode fetch. It holds the master interrupt enable, the program counter and the stack pointer. It produces the two stack writes that save the return address and loads the service vector into the PC.

The decoder reports enable, disable, return-from-interrupt and halt through one-cycle strobes. A halt strobe parks the core in a low-activity state or, if interrupts are masked and one is already waiting, sets up a one-shot fetch that leaves the PC unchanged, so the byte after the halt runs twice. Jumps and stack-pointer writes from the rest of the core arrive on plain load ports. One clock is one machine cycle.

Top module: `irq_halt_seq`

## Requirements
- R1: After reset the enable (`ime_o`) is 0, no enable is waiting, `pc_o` is 0x0100, `sp_o` is 0xFFFE, `state_o` is 0 (run) and no fetch, push or acknowledge is driven.
- R2: In run state with `boundary` high, no stall and no interrupt to take, `fetch_go` is high for that cycle and `pc_o` is one higher on the next cycle; `jump_en` loads `jump_addr` into the PC instead.
- R3: An enable strobe (`op_ei`) sets `ime_o` only in the cycle after the next fetch grant, so an interrupt pending at that grant is not entered until a later boundary.
- R4: `op_di` clears `ime_o` and `op_reti` sets it, both from the next cycle.
- R5: Interrupt entry (run, boundary, enable set, pending) writes the PC high byte to SP−1 in the entry cycle. The next cycle pulses `irq_ack` and writes the PC low byte to SP−2. SP ends 2 lower, and `ime_o` is 0 from the cycle after entry.
- R6: In the acknowledge cycle the PC is loaded with 0x40 + 8 × `irq_index` for index 0 to 4, or with 0x0000 if `irq_pending` is low in that cycle.
- R7: Entry occupies five cycles with `state_o` = 3: the two write cycles, then three cycles with no fetch and no write.
- R8: A halt strobe with the enable set puts the block in halted state (`state_o` = 2, no fetch). When an interrupt becomes pending, the block returns to run and enters the interrupt.
- R9: A halt strobe with the enable clear and nothing pending also halts; when an interrupt becomes pending the block resumes fetching without entering it.
- R10: A halt strobe with the enable clear and an interrupt pending does not halt. The next fetch grant asserts `fetch_noinc` and leaves the PC unchanged; the following grant increments again.
- R11: On wake from halt, colour mode (`colour_mode` = 1) inserts one cycle with `state_o` = 4 before run; mono mode inserts none.
- R12: While `stop_active` or `dma_busy` is high in run or halted state, `state_o` is 1 and no fetch, write or wake takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| colour_mode | input | 1 | 1 selects the extra wake cycle |
| stop_active | input | 1 | Core is in stop mode |
| dma_busy | input | 1 | A DMA transfer owns the bus |
| irq_pending | input | 1 | A priority-resolved interrupt is pending |
| irq_index | input | 3 | Index of the winning interrupt |
| boundary | input | 1 | Core waits for a decision between instructions |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_di | input | 1 | Disable-interrupts strobe |
| op_reti | input | 1 | Return-from-interrupt strobe |
| op_halt | input | 1 | Halt strobe |
| jump_en | input | 1 | Load `jump_addr` into the PC |
| jump_addr | input | 16 | Jump target |
| sp_load | input | 1 | Load `sp_value` into SP |
| sp_value | input | 16 | New SP |
| fetch_go | output | 1 | Opcode fetch granted this cycle |
| fetch_noinc | output | 1 | This fetch leaves the PC unchanged |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| push_we | output | 1 | Stack write request |
| push_addr | output | 16 | Stack write address |
| push_data | output | 8 | Stack write data |
| irq_ack | output | 1 | Acknowledge pulse to the interrupt controller |
| ime_o | output | 1 | Master interrupt enable |
| state_o | output | 3 | 0 run, 1 stalled, 2 halted, 3 servicing, 4 waking |

## Verification
The assertions watch, on every cycle, the local rules of the sequence. The acknowledge always follows a high-byte write and is followed by idle cycles. Each push lowers SP by one, and the enable is already clear when the acknowledge fires. Stalled and halted cycles never fetch or write, a plain fetch advances the PC by one and a no-increment fetch holds it, and the disable and return strobes take effect on the next cycle. Other rules span many cycles or depend on what the stimulus did earlier, and only the bench's scenarios can show them. These are the one-fetch delay of the enable, the three-way halt choice and the single repeated fetch, the zero vector when the request is withdrawn, and the extra wake cycle in colour mode.

// File: rtl/ihs_pkg.sv
package ihs_pkg;

  // Externally visible sequencer state
  typedef enum logic [2:0] {
    VIS_RUN   = 3'd0,
    VIS_STALL = 3'd1,
    VIS_HALT  = 3'd2,
    VIS_SVC   = 3'd3,
    VIS_WAKE  = 3'd4
  } vis_state_e;

  // Internal controller phase
  typedef enum logic [2:0] {
    PH_RUN    = 3'd0,
    PH_HALT   = 3'd1,
    PH_WAKE   = 3'd2,
    PH_PUSHLO = 3'd3,
    PH_IDLE   = 3'd4
  } phase_e;

endpackage

// File: rtl/irq_vec_sel.sv
module irq_vec_sel #(
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 3,
  parameter int NUM_IRQ  = 5,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8
) (
  input  logic              pending,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] vec
);

  logic [ADDR_W-1:0] slot [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
    assign slot[g] = ADDR_W'(VEC_BASE + g * VEC_STEP);
  end

  // Withdrawn request or out-of-range index lands at address zero
  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pending && (idx == IDX_W'(i))) vec = slot[i];
    end
  end

endmodule

// File: rtl/irq_en_ctl.sv
module irq_en_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic op_ei,
  input  logic op_di,
  input  logic op_reti,
  input  logic svc_start,
  input  logic fetch_go,
  output logic ime
);

  logic ime_q, ime_d;
  logic arm_q, arm_d;

  always_comb begin
    ime_d = ime_q;
    arm_d = arm_q;
    if (fetch_go && arm_q) begin
      ime_d = 1'b1;
      arm_d = 1'b0;
    end
    if (op_ei)     arm_d = 1'b1;
    if (op_di)     ime_d = 1'b0;
    if (op_reti)   ime_d = 1'b1;
    if (svc_start) ime_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      ime_q <= ime_d;
      arm_q <= arm_d;
    end
  end

  assign ime = ime_q;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import ihs_pkg::*;
#(
  parameter int IDLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       colour_mode,
  input  logic       stop_active,
  input  logic       dma_busy,
  input  logic       irq_pending,
  input  logic       boundary,
  input  logic       op_halt,
  input  logic       ime,
  output logic       fetch_go,
  output logic       fetch_noinc,
  output logic       push_hi,
  output logic       push_lo,
  output logic [2:0] state_o
);

  localparam int CNT_W = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYC - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             rep_q, rep_d;
  logic             stall, take, decide;

  assign stall   = ((ph_q == PH_RUN) || (ph_q == PH_HALT)) && (stop_active || dma_busy);
  assign decide  = (ph_q == PH_RUN) && boundary && !stall;
  assign take    = decide && ime && irq_pending;
  assign fetch_go    = decide && !take;
  assign fetch_noinc = fetch_go && rep_q;
  assign push_hi = take;
  assign push_lo = (ph_q == PH_PUSHLO);

  always_comb begin
    if (stall) begin
      state_o = VIS_STALL;
    end else begin
      case (ph_q)
        PH_RUN:  state_o = take ? VIS_SVC : VIS_RUN;
        PH_HALT: state_o = VIS_HALT;
        PH_WAKE: state_o = VIS_WAKE;
        default: state_o = VIS_SVC;
      endcase
    end
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    rep_d  = rep_q;
    case (ph_q)
      PH_RUN: begin
        if (fetch_go) rep_d = 1'b0;
        if (take) begin
          ph_d = PH_PUSHLO;
        end else if (op_halt) begin
          if (!ime && irq_pending) rep_d = 1'b1;
          else                     ph_d  = PH_HALT;
        end
      end
      PH_PUSHLO: begin
        ph_d   = PH_IDLE;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
      PH_IDLE: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) ph_d  = PH_RUN;
        else                   cnt_d = cnt_q + 1'b1;
      end
      PH_HALT: begin
        if (!stall && irq_pending) ph_d = colour_mode ? PH_WAKE : PH_RUN;
      end
      PH_WAKE: ph_d = PH_RUN;
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_RUN;
      cnt_q <= '0;
      rep_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rep_q <= rep_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ptr_regs.sv
module ptr_regs #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PC_RESET = 16'h0100,
  parameter logic [ADDR_W-1:0] SP_RESET = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic              fetch_noinc,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              vec_load,
  input  logic [ADDR_W-1:0] vec,
  input  logic              push,
  input  logic              sp_load,
  input  logic [ADDR_W-1:0] sp_value,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp
);

  logic [ADDR_W-1:0] pc_q, pc_d, sp_q, sp_d;
  logic              pc_en, sp_en;

  always_comb begin
    pc_en = 1'b1;
    if (vec_load)                     pc_d = vec;
    else if (jump_en)                 pc_d = jump_addr;
    else if (fetch_go && !fetch_noinc) pc_d = pc_q + 1'b1;
    else begin
      pc_d  = pc_q;
      pc_en = 1'b0;
    end
  end

  always_comb begin
    sp_en = 1'b1;
    if (push)         sp_d = sp_q - 1'b1;
    else if (sp_load) sp_d = sp_value;
    else begin
      sp_d  = sp_q;
      sp_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= PC_RESET;
      sp_q <= SP_RESET;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (sp_en) sp_q <= sp_d;
    end
  end

  assign pc = pc_q;
  assign sp = sp_q;

endmodule

// File: rtl/irq_halt_seq.sv
module irq_halt_seq #(
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 3,
  parameter int NUM_IRQ  = 5,
  parameter int VEC_BASE = 'h40,
  parameter int VEC_STEP = 8,
  parameter int IDLE_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  colour_mode,
  input  logic                  stop_active,
  input  logic                  dma_busy,
  input  logic                  irq_pending,
  input  logic [IDX_W-1:0]      irq_index,
  input  logic                  boundary,
  input  logic                  op_ei,
  input  logic                  op_di,
  input  logic                  op_reti,
  input  logic                  op_halt,
  input  logic                  jump_en,
  input  logic [2*DATA_W-1:0]   jump_addr,
  input  logic                  sp_load,
  input  logic [2*DATA_W-1:0]   sp_value,
  output logic                  fetch_go,
  output logic                  fetch_noinc,
  output logic [2*DATA_W-1:0]   pc_o,
  output logic [2*DATA_W-1:0]   sp_o,
  output logic                  push_we,
  output logic [2*DATA_W-1:0]   push_addr,
  output logic [DATA_W-1:0]     push_data,
  output logic                  irq_ack,
  output logic                  ime_o,
  output logic [2:0]            state_o
);

  localparam int ADDR_W = 2 * DATA_W;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic              push_hi, push_lo, ime;
  logic [ADDR_W-1:0] vec, pc, sp;

  seq_fsm #(.IDLE_CYC(IDLE_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync),
    .colour_mode (colour_mode),
    .stop_active (stop_active),
    .dma_busy    (dma_busy),
    .irq_pending (irq_pending),
    .boundary    (boundary),
    .op_halt     (op_halt),
    .ime         (ime),
    .fetch_go    (fetch_go),
    .fetch_noinc (fetch_noinc),
    .push_hi     (push_hi),
    .push_lo     (push_lo),
    .state_o     (state_o)
  );

  irq_en_ctl u_en (
    .clk       (clk),
    .rst_n     (rst_sync),
    .op_ei     (op_ei),
    .op_di     (op_di),
    .op_reti   (op_reti),
    .svc_start (push_hi),
    .fetch_go  (fetch_go),
    .ime       (ime)
  );

  irq_vec_sel #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_IRQ(NUM_IRQ),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_vec (
    .pending (irq_pending),
    .idx     (irq_index),
    .vec     (vec)
  );

  ptr_regs #(.ADDR_W(ADDR_W)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_sync),
    .fetch_go    (fetch_go),
    .fetch_noinc (fetch_noinc),
    .jump_en     (jump_en),
    .jump_addr   (jump_addr),
    .vec_load    (push_lo),
    .vec         (vec),
    .push        (push_hi | push_lo),
    .sp_load     (sp_load),
    .sp_value    (sp_value),
    .pc          (pc),
    .sp          (sp)
  );

  assign push_we   = push_hi | push_lo;
  assign push_addr = sp - 1'b1;
  assign push_data = push_hi ? pc[ADDR_W-1:DATA_W] : pc[DATA_W-1:0];
  assign irq_ack   = push_lo;
  assign ime_o     = ime;
  assign pc_o      = pc;
  assign sp_o      = sp;

endmodule

// File: rtl/irq_halt_seq_chk.sv
module irq_halt_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_di,
  input logic        op_reti,
  input logic        jump_en,
  input logic        sp_load,
  input logic        fetch_go,
  input logic        fetch_noinc,
  input logic        push_we,
  input logic        irq_ack,
  input logic        ime_o,
  input logic [2:0]  state_o,
  input logic [15:0] pc_o,
  input logic [15:0] sp_o
);

  // R5
  hi_then_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_we && !irq_ack) |=> (push_we && irq_ack));

  // R5
  ime_clear_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !ime_o);

  // R5
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_we && !sp_load) |=> (sp_o == $past(sp_o) - 16'd1));

  // R7
  idle_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!push_we && !fetch_go && state_o == 3'd3));

  // R12
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1) |-> (!fetch_go && !push_we));

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |-> (!fetch_go && !push_we));

  // R4
  di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_di && !op_reti) |=> !ime_o);

  // R4
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_reti && !op_di && !push_we) |=> ime_o);

  // R10
  noinc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_noinc && !jump_en) |=> $stable(pc_o));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_go && !fetch_noinc && !jump_en) |=> (pc_o == $past(pc_o) + 16'd1));

  // R11
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |=> (state_o != 3'd4));

endmodule

bind irq_halt_seq irq_halt_seq_chk u_chk (.*);

// File: tb/sim_irq_halt_seq.sv
module sim_irq_halt_seq;

  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        colour_mode, stop_active, dma_busy, irq_pending;
  logic [2:0]  irq_index;
  logic        boundary, op_ei, op_di, op_reti, op_halt, jump_en, sp_load;
  logic [15:0] jump_addr, sp_value;
  logic        fetch_go, fetch_noinc, push_we, irq_ack, ime_o;
  logic [15:0] pc_o, sp_o, push_addr;
  logic [7:0]  push_data;
  logic [2:0]  state_o;

  always #(PER/2) clk = ~clk;

  irq_halt_seq u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int          m_mode;   // 0 run, 2 halted, 3 servicing, 4 waking
  int          m_step;
  bit          m_ime, m_arm, m_rep;
  logic [15:0] m_pc, m_sp;

  function automatic logic [15:0] vec_of(input bit p, input logic [2:0] i);
    if (!p) return 16'h0000;
    case (i)
      3'd0: return 16'h0040;
      3'd1: return 16'h0048;
      3'd2: return 16'h0050;
      3'd3: return 16'h0058;
      3'd4: return 16'h0060;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    bit e_stall, e_take, e_fetch, e_noinc, e_ack, e_we;
    int e_state;
    #1;
    e_stall = (m_mode == 0 || m_mode == 2) && (stop_active || dma_busy);
    e_take  = (m_mode == 0) && boundary && !e_stall && m_ime && irq_pending;
    e_fetch = (m_mode == 0) && boundary && !e_stall && !e_take;
    e_noinc = e_fetch && m_rep;
    e_ack   = (m_mode == 3) && (m_step == 1);
    e_we    = e_take || e_ack;
    e_state = e_stall ? 1 : (m_mode == 0 ? (e_take ? 3 : 0) : m_mode);
    chk(cur_req, "fetch_go", fetch_go, e_fetch);
    chk(cur_req, "fetch_noinc", fetch_noinc, e_noinc);
    chk(cur_req, "push_we", push_we, e_we);
    chk(cur_req, "irq_ack", irq_ack, e_ack);
    chk(cur_req, "state_o", state_o, e_state);
    chk(cur_req, "pc_o", pc_o, m_pc);
    chk(cur_req, "sp_o", sp_o, m_sp);
    chk(cur_req, "ime_o", ime_o, m_ime);
    if (e_we) begin
      chk(cur_req, "push_addr", push_addr, m_sp - 16'd1);
      chk(cur_req, "push_data", push_data, e_take ? m_pc[15:8] : m_pc[7:0]);
    end
    @(posedge clk);
    // advance the reference by one machine cycle
    if (e_fetch) begin
      if (!m_rep) m_pc = m_pc + 16'd1;
      m_rep = 0;
      if (m_arm) begin m_ime = 1; m_arm = 0; end
    end
    if (op_ei) m_arm = 1;
    if (op_di) m_ime = 0;
    if (op_reti) m_ime = 1;
    if (jump_en) m_pc = jump_addr;
    if (sp_load) m_sp = sp_value;
    case (m_mode)
      0: begin
        if (e_take) begin
          m_sp = m_sp - 16'd1; m_ime = 0; m_mode = 3; m_step = 1;
        end else if (op_halt) begin
          if (!m_ime && irq_pending) m_rep = 1;
          else m_mode = 2;
        end
      end
      2: if (!e_stall && irq_pending) m_mode = colour_mode ? 4 : 0;
      4: m_mode = 0;
      3: begin
        if (m_step == 1) begin
          m_sp = m_sp - 16'd1;
          m_pc = vec_of(irq_pending, irq_index);
        end
        if (m_step == 4) m_mode = 0;
        else m_step = m_step + 1;
      end
      default: m_mode = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic pulse_reti();
    op_reti = 1; cyc(1); op_reti = 0;
  endtask

  task automatic pulse_halt();
    op_halt = 1; cyc(1); op_halt = 0;
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; colour_mode = 0; stop_active = 0; dma_busy = 0;
    irq_pending = 0; irq_index = 0; boundary = 0;
    op_ei = 0; op_di = 0; op_reti = 0; op_halt = 0;
    jump_en = 0; jump_addr = 0; sp_load = 0; sp_value = 0;
    m_mode = 0; m_step = 0; m_ime = 0; m_arm = 0; m_rep = 0;
    m_pc = 16'h0100; m_sp = 16'hFFFE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; cyc(4);
    chk("R1", "pc reset", pc_o, 16'h0100);
    chk("R1", "sp reset", sp_o, 16'hFFFE);
    chk("R1", "ime reset", ime_o, 0);
    chk("R1", "state reset", state_o, 0);

    cur_req = "R2"; boundary = 1; cyc(3); boundary = 0;
    chk("R2", "pc after 3 fetches", pc_o, 16'h0103);
    jump_en = 1; jump_addr = 16'h1234; cyc(1); jump_en = 0;
    chk("R2", "pc after jump", pc_o, 16'h1234);

    cur_req = "R4"; pulse_reti();
    chk("R4", "ime after reti", ime_o, 1);
    op_di = 1; cyc(1); op_di = 0;
    chk("R4", "ime after di", ime_o, 0);

    cur_req = "R3"; op_ei = 1; cyc(1); op_ei = 0;
    chk("R3", "ime before next fetch", ime_o, 0);
    irq_pending = 1; irq_index = 3'd2; boundary = 1; cyc(1);
    chk("R3", "ime after next fetch", ime_o, 1);
    chk("R3", "pc after delayed fetch", pc_o, 16'h1235);
    boundary = 0; cyc(1);
    cur_req = "R5"; boundary = 1; cyc(2);
    chk("R6", "vector idx2", pc_o, 16'h0050);
    chk("R5", "sp after entry", sp_o, 16'hFFFC);
    chk("R5", "ime after entry", ime_o, 0);
    cur_req = "R7"; irq_pending = 0; cyc(4); boundary = 0;
    chk("R7", "pc after post-entry fetch", pc_o, 16'h0051);

    cur_req = "R6"; pulse_reti();
    irq_pending = 1; irq_index = 3'd0; boundary = 1; cyc(1);
    irq_pending = 0; cyc(1);
    chk("R6", "withdrawn vector", pc_o, 16'h0000);
    cyc(3); boundary = 0;
    pulse_reti();
    irq_pending = 1; irq_index = 3'd4; boundary = 1; cyc(2);
    chk("R6", "vector idx4", pc_o, 16'h0060);
    chk("R5", "sp after three entries", sp_o, 16'hFFF8);
    irq_pending = 0; cyc(3); boundary = 0;

    cur_req = "R8"; pulse_reti(); pulse_halt();
    boundary = 1; cyc(3);
    chk("R8", "halted state", state_o, 2);
    irq_pending = 1; irq_index = 3'd1; cyc(3);
    chk("R8", "vector after wake", pc_o, 16'h0048);
    irq_pending = 0; cyc(3); boundary = 0;

    cur_req = "R11"; colour_mode = 1; pulse_reti(); pulse_halt();
    boundary = 1; cyc(2);
    irq_pending = 1; irq_index = 3'd3; cyc(1);
    chk("R11", "wake state colour", state_o, 4);
    cyc(3);
    chk("R11", "vector after colour wake", pc_o, 16'h0058);
    irq_pending = 0; cyc(3); boundary = 0; colour_mode = 0;

    cur_req = "R9"; pulse_halt();
    boundary = 1; cyc(2);
    chk("R9", "halted with ime clear", state_o, 2);
    irq_pending = 1; irq_index = 3'd0; cyc(1);
    chk("R11", "mono wake goes straight to run", state_o, 0);
    cyc(1);
    chk("R9", "resume without entry", pc_o, 16'h0059);
    irq_pending = 0; boundary = 0; cyc(1);

    cur_req = "R10"; irq_pending = 1; pulse_halt();
    chk("R10", "no halt on masked pending", state_o, 0);
    boundary = 1; cyc(1);
    chk("R10", "pc held by repeat fetch", pc_o, 16'h0059);
    cyc(1);
    chk("R10", "pc after following fetch", pc_o, 16'h005A);
    boundary = 0; irq_pending = 0; cyc(1);

    cur_req = "R12"; stop_active = 1; boundary = 1; cyc(3);
    chk("R12", "stop stalls", state_o, 1);
    stop_active = 0; dma_busy = 1; cyc(2);
    chk("R12", "dma keeps pc", pc_o, 16'h005A);
    dma_busy = 0; boundary = 0;
    pulse_halt();
    dma_busy = 1; irq_pending = 1; cyc(2);
    chk("R12", "stalled while halted", state_o, 1);
    dma_busy = 0; cyc(1);
    irq_pending = 0; boundary = 1; cyc(1); boundary = 0;
    chk("R12", "fetch after stalled wake", pc_o, 16'h005B);
    cyc(2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule